// File: doc/BRIEF.md
# 32-bit Integer ALU with Overflow Trap

This block is the execute-stage arithmetic unit of a load-store integer pipeline. It is purely combinational: given two register operands, a 16-bit immediate, a constant shift amount and a 4-bit operation code, it returns a 32-bit result in the same cycle. It also returns a trap flag for signed overflow and a write-enable for the destination register. The decoder sets the operation code and source selects, and the register file consumes the result.

The second operand is either the register value or the immediate, and the immediate passes through an extender inside the block. The decoder chooses the extension: zero extension for the logical immediates, sign extension for the arithmetic and compare immediates, including the non-trapping add. Shifts always act on the second register operand. Their amount comes either from the constant field or from the low five bits of the first register operand.

Top module: `int_alu`

## Requirements
- R1: `opSel` encodes ADD=0, ADDU=1, SUB=2, SUBU=3, AND=4, OR=5, XOR=6, NOR=7, SLT=8, SLTU=9, SLL=10, SRL=11, SRA=12, LUI=13. ADD/ADDU give A+B and SUB/SUBU give A-B, both modulo 2^32. Codes 14 and 15 give result 0 and no trap.
- R2: `trap` is 1 only for ADD or SUB whose two's-complement result overflows. ADDU, SUBU, the logical ops, the compares, the shifts and LUI never raise it.
- R3: `wrEn` is 0 exactly when `trap` is 1, and 1 otherwise.
- R4: AND, OR and XOR give the bitwise function of A and B. NOR gives the bitwise complement of A OR B.
- R5: SLT gives 1 when A < B as signed two's-complement values and 0 otherwise. SLTU does the same comparison with A and B as unsigned numbers. Bits [31:1] of the result are always 0.
- R6: SLL shifts `srcB` left and SRL shifts it right, both filling vacated bits with 0. SRA shifts `srcB` right and fills vacated bits with `srcB[31]`.
- R7: With `shiftVar`=0 the shift amount is `shamt`. With `shiftVar`=1 it is `srcA[4:0]`, and `srcA[31:5]` has no effect.
- R8: LUI gives `{imm16, 16'h0000}` whatever the values of `srcA` and `srcB`.
- R9: With `useImm`=0, B is `srcB`. With `useImm`=1, B is `imm16` sign-extended when `immSignExt`=1 and zero-extended when `immSignExt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code (see R1) |
| srcA | input | 32 | First register operand; shift amount source for variable shifts |
| srcB | input | 32 | Second register operand; value shifted by shifts |
| imm16 | input | 16 | Immediate constant |
| useImm | input | 1 | 1 selects the extended immediate as B |
| immSignExt | input | 1 | 1 sign-extends, 0 zero-extends the immediate |
| shamt | input | 5 | Constant shift amount |
| shiftVar | input | 1 | 1 takes the shift amount from srcA[4:0] |
| result | output | 32 | Operation result |
| trap | output | 1 | Signed overflow on a trapping add/subtract |
| wrEn | output | 1 | Destination write enable |

## Verification
The assertions sit in combinational processes and take every input as a settled, known value. They relate the operation code presented at the port to the result and the trap, so they assume that `opSel` changes only together with the operands. The bench applies each complete input vector in one step shortly after a clock edge and holds it until the next edge. It compares the outputs at the falling edge, when nothing is changing. It drives only legal one-bit selects and covers every operation code, including the two unused ones.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_SRA  = 4'd12,
    OP_LUI  = 4'd13
  } aluOp_e;

  typedef enum logic [2:0] {
    RES_ZERO,
    RES_ARITH,
    RES_LOGIC,
    RES_CMP,
    RES_SHIFT,
    RES_UPPER
  } resSel_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_NOR
  } logicFn_e;

  typedef struct packed {
    resSel_e  resSel;
    logicFn_e logicFn;
    logic     doSub;
    logic     trapEn;
    logic     cmpUnsigned;
    logic     shiftRight;
    logic     shiftArith;
  } ctlStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]  opSel,
  output ctlStrobes_t ctl
);

  always_comb begin
    ctl             = '0;
    ctl.resSel      = RES_ZERO;
    ctl.logicFn     = LG_AND;
    case (opSel)
      OP_ADD:  begin ctl.resSel = RES_ARITH; ctl.trapEn = 1'b1; end
      OP_ADDU: begin ctl.resSel = RES_ARITH; end
      OP_SUB:  begin ctl.resSel = RES_ARITH; ctl.doSub = 1'b1; ctl.trapEn = 1'b1; end
      OP_SUBU: begin ctl.resSel = RES_ARITH; ctl.doSub = 1'b1; end
      OP_AND:  begin ctl.resSel = RES_LOGIC; ctl.logicFn = LG_AND; end
      OP_OR:   begin ctl.resSel = RES_LOGIC; ctl.logicFn = LG_OR; end
      OP_XOR:  begin ctl.resSel = RES_LOGIC; ctl.logicFn = LG_XOR; end
      OP_NOR:  begin ctl.resSel = RES_LOGIC; ctl.logicFn = LG_NOR; end
      OP_SLT:  begin ctl.resSel = RES_CMP; ctl.doSub = 1'b1; end
      OP_SLTU: begin ctl.resSel = RES_CMP; ctl.doSub = 1'b1; ctl.cmpUnsigned = 1'b1; end
      OP_SLL:  begin ctl.resSel = RES_SHIFT; end
      OP_SRL:  begin ctl.resSel = RES_SHIFT; ctl.shiftRight = 1'b1; end
      OP_SRA:  begin ctl.resSel = RES_SHIFT; ctl.shiftRight = 1'b1; ctl.shiftArith = 1'b1; end
      OP_LUI:  begin ctl.resSel = RES_UPPER; end
      default: begin ctl.resSel = RES_ZERO; end
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = 16,
  localparam int SHW = $clog2(W)
) (
  input  ctlStrobes_t     ctl,
  input  logic [W-1:0]    srcA,
  input  logic [W-1:0]    srcB,
  input  logic [IMMW-1:0] imm,
  input  logic            useImm,
  input  logic            immSignExt,
  input  logic [SHW-1:0]  shamt,
  input  logic            shiftVar,
  output logic [W-1:0]    result,
  output logic            trap
);

  localparam int PADW = W - IMMW;

  logic [W-1:0]   immExt;
  logic [W-1:0]   opB;
  logic [W-1:0]   bAdj;
  logic [W:0]     sumFull;
  logic [W-1:0]   sum;
  logic           carryOut;
  logic           signedOvf;
  logic           lessSigned;
  logic           lessUnsigned;
  logic [W-1:0]   logicRes;
  logic [SHW-1:0] shAmt;
  logic [W-1:0]   shLeft;
  logic signed [W:0] shExt;
  logic signed [W:0] shRightFull;
  logic [W-1:0]   shRes;

  // Immediate extender in front of operand B
  always_comb begin
    immExt = immSignExt ? {{PADW{imm[IMMW-1]}}, imm} : {{PADW{1'b0}}, imm};
    opB    = useImm ? immExt : srcB;
  end

  // Shared adder for add, subtract and compares
  always_comb begin
    bAdj      = ctl.doSub ? ~opB : opB;
    sumFull   = {1'b0, srcA} + {1'b0, bAdj} + {{W{1'b0}}, ctl.doSub};
    sum       = sumFull[W-1:0];
    carryOut  = sumFull[W];
    signedOvf = (srcA[W-1] == bAdj[W-1]) && (sum[W-1] != srcA[W-1]);
    lessSigned   = (srcA[W-1] != opB[W-1]) ? srcA[W-1] : sum[W-1];
    lessUnsigned = ~carryOut;
  end

  always_comb begin
    case (ctl.logicFn)
      LG_AND:  logicRes = srcA & opB;
      LG_OR:   logicRes = srcA | opB;
      LG_XOR:  logicRes = srcA ^ opB;
      default: logicRes = ~(srcA | opB);
    endcase
  end

  // Shifter: value from srcB, amount from constant field or srcA low bits
  always_comb begin
    shAmt       = shiftVar ? srcA[SHW-1:0] : shamt;
    shLeft      = srcB << shAmt;
    shExt       = {ctl.shiftArith & srcB[W-1], srcB};
    shRightFull = shExt >>> shAmt;
    shRes       = ctl.shiftRight ? shRightFull[W-1:0] : shLeft;
  end

  always_comb begin
    case (ctl.resSel)
      RES_ARITH: result = sum;
      RES_LOGIC: result = logicRes;
      RES_CMP:   result = {{(W-1){1'b0}}, ctl.cmpUnsigned ? lessUnsigned : lessSigned};
      RES_SHIFT: result = shRes;
      RES_UPPER: result = {imm, {PADW{1'b0}}};
      default:   result = '0;
    endcase
    trap = ctl.trapEn & signedOvf;
  end

  always_comb begin
    if (ctl.resSel == RES_SHIFT && ctl.shiftRight && !ctl.shiftArith && shAmt != '0)
      AST_SRL_ZERO_FILL: assert (!result[W-1]); // R6
    if (ctl.resSel == RES_SHIFT && !ctl.shiftRight && shAmt != '0)
      AST_SLL_ZERO_FILL: assert (!result[0]); // R6
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
(
  input  logic [3:0]  opSel,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  input  logic [15:0] imm16,
  input  logic        useImm,
  input  logic        immSignExt,
  input  logic [4:0]  shamt,
  input  logic        shiftVar,
  output logic [31:0] result,
  output logic        trap,
  output logic        wrEn
);

  ctlStrobes_t ctl;

  alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctl   (ctl)
  );

  alu_datapath #(.W(32), .IMMW(16)) u_dp (
    .ctl        (ctl),
    .srcA       (srcA),
    .srcB       (srcB),
    .imm        (imm16),
    .useImm     (useImm),
    .immSignExt (immSignExt),
    .shamt      (shamt),
    .shiftVar   (shiftVar),
    .result     (result),
    .trap       (trap)
  );

  assign wrEn = ~trap;

  always_comb begin
    if (opSel != OP_ADD && opSel != OP_SUB)
      AST_NO_OVERFLOW: assert (!trap); // R2
    if (opSel == OP_SLT || opSel == OP_SLTU)
      AST_CMP_ONE_BIT: assert (result[31:1] == 31'd0); // R5
    if (opSel == OP_LUI)
      AST_UPPER_LOW_ZERO: assert (result[15:0] == 16'd0); // R8
    if (opSel == 4'd14 || opSel == 4'd15)
      AST_UNUSED_ZERO: assert (result == 32'd0); // R1
  end

endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;

  logic        clk = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [15:0] imm16 = '0;
  logic        useImm = 1'b0;
  logic        immSignExt = 1'b0;
  logic [4:0]  shamt = '0;
  logic        shiftVar = 1'b0;
  logic [31:0] result;
  logic        trap;
  logic        wrEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] res;
    logic        trp;
    string       tag;
  } expItem_t;

  expItem_t sbQueue[$];

  always #10 clk = ~clk;

  int_alu u_dut (
    .opSel(opSel), .srcA(srcA), .srcB(srcB), .imm16(imm16),
    .useImm(useImm), .immSignExt(immSignExt), .shamt(shamt),
    .shiftVar(shiftVar), .result(result), .trap(trap), .wrEn(wrEn)
  );

  function automatic expItem_t model(logic [3:0] op, logic [31:0] a, logic [31:0] rb,
                                     logic [15:0] im, logic ui, logic sx,
                                     logic [4:0] sh, logic sv, string tag);
    expItem_t e;
    logic [31:0] b;
    longint sa, sb, s;
    int amt;
    b = ui ? (sx ? {{16{im[15]}}, im} : {16'h0, im}) : rb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    amt = sv ? int'(a[4:0]) : int'(sh);
    e.trp = 1'b0;
    e.tag = tag;
    case (op)
      4'd0, 4'd1: begin
        e.res = a + b;
        s = sa + sb;
        if (op == 4'd0) e.trp = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      4'd2, 4'd3: begin
        e.res = a - b;
        s = sa - sb;
        if (op == 4'd2) e.trp = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      4'd4: e.res = a & b;
      4'd5: e.res = a | b;
      4'd6: e.res = a ^ b;
      4'd7: e.res = ~(a | b);
      4'd8: e.res = (sa < sb) ? 32'd1 : 32'd0;
      4'd9: e.res = (a < b) ? 32'd1 : 32'd0;
      4'd10: e.res = rb << amt;
      4'd11: e.res = rb >> amt;
      4'd12: e.res = 32'($signed(rb) >>> amt);
      4'd13: e.res = {im, 16'h0};
      default: e.res = 32'd0;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic ui, input logic sx,
                       input logic [4:0] sh, input logic sv, input string tag);
    @(posedge clk);
    #1;
    opSel = op; srcA = a; srcB = b; imm16 = im;
    useImm = ui; immSignExt = sx; shamt = sh; shiftVar = sv;
    sbQueue.push_back(model(op, a, b, im, ui, sx, sh, sv, tag));
  endtask

  // Monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbQueue.size() > 0) begin
        expItem_t e;
        e = sbQueue.pop_front();
        checks++;
        if (result !== e.res || trap !== e.trp || wrEn !== ~e.trp) begin
          errors++;
          $display("FAIL %s: result=%h trap=%b wrEn=%b expected result=%h trap=%b wrEn=%b",
                   e.tag, result, trap, wrEn, e.res, e.trp, ~e.trp);
        end
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // idle state: all-zero inputs give an ADD of zeros
    drive(4'd0, 32'h0, 32'h0, 16'h0, 0, 0, 5'd0, 0, "R1 idle");
    // R1 arithmetic
    drive(4'd0, 32'd7, 32'd5, 16'h0, 0, 0, 5'd0, 0, "R1 add");
    drive(4'd3, 32'd3, 32'd5, 16'h0, 0, 0, 5'd0, 0, "R1 subu wrap");
    drive(4'd14, 32'hFFFF_FFFF, 32'h1234, 16'hFFFF, 0, 0, 5'd3, 0, "R1 unused 14");
    drive(4'd15, 32'h7FFF_FFFF, 32'h1, 16'h0, 0, 0, 5'd0, 0, "R1 unused 15");
    // R2 / R3 overflow
    drive(4'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 0, 0, 5'd0, 0, "R2 R3 add ovf");
    drive(4'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 0, 0, 5'd0, 0, "R2 addu no trap");
    drive(4'd2, 32'h8000_0000, 32'h1, 16'h0, 0, 0, 5'd0, 0, "R2 R3 sub ovf");
    drive(4'd3, 32'h8000_0000, 32'h1, 16'h0, 0, 0, 5'd0, 0, "R2 subu no trap");
    drive(4'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001, 1, 1, 5'd0, 0, "R2 addi ovf");
    drive(4'd0, 32'h8000_0000, 32'h0, 16'hFFFF, 1, 1, 5'd0, 0, "R2 addi neg ovf");
    drive(4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 0, 0, 5'd0, 0, "R2 sub ovf pos");
    // R4 logic
    drive(4'd4, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, 0, 0, 5'd0, 0, "R4 and");
    drive(4'd5, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, 0, 0, 5'd0, 0, "R4 or");
    drive(4'd6, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, 0, 0, 5'd0, 0, "R4 xor");
    drive(4'd7, 32'hF0F0_1234, 32'h0F00_FF00, 16'h0, 0, 0, 5'd0, 0, "R4 nor");
    // R5 compares
    drive(4'd8, 32'hFFFF_FFFF, 32'h1, 16'h0, 0, 0, 5'd0, 0, "R5 slt neg<pos");
    drive(4'd9, 32'hFFFF_FFFF, 32'h1, 16'h0, 0, 0, 5'd0, 0, "R5 sltu big");
    drive(4'd8, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, 0, 5'd0, 0, "R5 slt extremes");
    drive(4'd8, 32'd5, 32'd5, 16'h0, 0, 0, 5'd0, 0, "R5 slt equal");
    drive(4'd9, 32'd3, 32'h0, 16'h8000, 1, 1, 5'd0, 0, "R5 R9 sltiu sx");
    // R6 / R7 shifts
    drive(4'd10, 32'h0, 32'h8000_0001, 16'h0, 0, 0, 5'd4, 0, "R6 sll");
    drive(4'd11, 32'h0, 32'h8000_0010, 16'h0, 0, 0, 5'd4, 0, "R6 srl");
    drive(4'd12, 32'h0, 32'h8000_0010, 16'h0, 0, 0, 5'd4, 0, "R6 sra neg");
    drive(4'd12, 32'h0, 32'h4000_0010, 16'h0, 0, 0, 5'd31, 0, "R6 sra pos 31");
    drive(4'd11, 32'hFFFF_FFE3, 32'hFFFF_FFFF, 16'h0, 0, 0, 5'd1, 1, "R7 srlv low5");
    drive(4'd10, 32'h0000_0120, 32'h0000_0003, 16'h0, 0, 0, 5'd7, 1, "R7 sllv ignore hi");
    drive(4'd12, 32'h0000_001F, 32'h8000_0000, 16'h0, 0, 0, 5'd0, 1, "R7 srav 31");
    // R8 LUI
    drive(4'd13, 32'hDEAD_BEEF, 32'h1234_5678, 16'hABCD, 0, 0, 5'd9, 0, "R8 lui");
    drive(4'd13, 32'h0, 32'h0, 16'h8001, 1, 1, 5'd0, 0, "R8 lui sx");
    // R9 extender
    drive(4'd5, 32'h0000_0000, 32'hFFFF_FFFF, 16'h8000, 1, 0, 5'd0, 0, "R9 ori zero ext");
    drive(4'd1, 32'h0000_0010, 32'h0, 16'hFFFF, 1, 1, 5'd0, 0, "R9 addiu sx");
    drive(4'd4, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 1, 0, 5'd0, 0, "R9 andi zx");
    // random sweep across all codes
    for (int i = 0; i < 300; i++) begin
      drive(4'($urandom_range(0, 15)), $urandom, $urandom, 16'($urandom),
            1'($urandom), 1'($urandom), 5'($urandom), 1'($urandom), "R1 random");
    end
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule